// File: doc/BRIEF.md
# Power Event Interrupt Flag Register

This block keeps sticky records of wake and power events for a low-power microcontroller. Three events are captured: a rising edge on the push-button input, a rise of the PLL-lock (system power good) level, and a fall of that level, which marks entry into brownout. Both asynchronous levels pass through a multi-stage synchronizer. A registered previous-value compare then turns each one into a single-cycle event pulse.

Each flag has its own enable bit. The enabled flags are ORed into one interrupt request. Software clears a flag by writing zero to its bit, and a one leaves the bit alone. A sleep or display-only mode request from the core also clears the button flag. A power-loss event is not recorded while a wake-source indication (button or wake timer) shows that the device woke into brownout. When an event and a clear reach the same flag in the same cycle, the event wins.

Flag bit positions, also used for the enable bits: bit 0 is button rise, bit 1 is lock rise, bit 2 is lock fall.

Top module: `pwr_evt_flags`

## Requirements
- R1: While reset is asserted, and after it is released with quiet inputs, `flags_o`, `enables_o` and `irq_o` are all zero.
- R2: A rising edge on `btn_i` sets flag bit 0 exactly SYNC_STAGES+1 rising clock edges after the input changes (3 with the default of 2). It is not set one edge earlier. A falling edge of `btn_i` sets nothing.
- R3: A rising edge on `lock_i` sets flag bit 1 with the same latency as in R2.
- R4: A falling edge on `lock_i` sets flag bit 2 with the same latency as in R2, when both `wake_btn_i` and `wake_tmr_i` are low.
- R5: While `wake_btn_i` or `wake_tmr_i` is high, a falling edge on `lock_i` leaves flag bit 2 clear.
- R6: A write with `wr_en_i`=1 and `wr_sel_i`=0 clears each flag whose bit in `wr_data_i` is 0. A bit written as 1 leaves its flag unchanged.
- R7: A cycle with `lp_req_i`=1 clears flag bit 0 and leaves bits 1 and 2 unchanged.
- R8: If a flag's event is detected in the same cycle as a software clear or a mode-request clear of that flag, the flag ends up set.
- R9: A write with `wr_en_i`=1 and `wr_sel_i`=1 loads `wr_data_i` into `enables_o` at the next edge. Enables do not change otherwise.
- R10: With the default IRQ_REG=0, `irq_o` is high in the same cycle as any flag whose enable bit is 1, and low otherwise.
- R11: A set flag stays set until it is cleared as described in R6 or R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_i | input | 1 | Push-button level, asynchronous |
| lock_i | input | 1 | PLL-lock / power-good level, asynchronous |
| wake_btn_i | input | 1 | Device woke into brownout because of the button |
| wake_tmr_i | input | 1 | Device woke into brownout because of the wake timer |
| lp_req_i | input | 1 | Core requests sleep or display-only mode |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 selects flags, 1 selects enables |
| wr_data_i | input | 3 | Write data, one bit per flag |
| flags_o | output | 3 | Sticky flags: bit 0 button rise, bit 1 lock rise, bit 2 lock fall |
| enables_o | output | 3 | Per-flag interrupt enables |
| irq_o | output | 1 | OR of the enabled flags |

## Verification
The two functions that can land on one edge are detecting an event and clearing the same flag, whether by a zero write or by a mode request. The bench makes an input change, waits until the next edge is the one on which the synchronized edge reaches the flag, and drives the clear in that same cycle. It then expects the flag to read set while the other cleared bits read zero. Around these directed collisions, seeded random writes and mode requests are checked against a bench model. Spaced input toggles are checked at the known latency.

// File: rtl/pwr_evt_pkg.sv
`timescale 1ns/1ps
package pwr_evt_pkg;
   localparam int FLAG_W    = 3;
   localparam int IDX_BTN   = 0;
   localparam int IDX_LRISE = 1;
   localparam int IDX_LFALL = 2;
   typedef logic [FLAG_W-1:0] flag_vec_t;
endpackage

// File: rtl/pwr_evt_sync.sv
`timescale 1ns/1ps
module pwr_evt_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pwr_evt_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("pwr_evt_sync: W must be positive");
      end
   endgenerate

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
      end else begin
         stg_q[0] <= d_i;
         for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pwr_evt_edge.sv
`timescale 1ns/1ps
module pwr_evt_edge #(
   parameter bit FALLING = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic evt_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_i;
   end

   generate
      if (FALLING) begin : g_fall
         assign evt_o = prev_q & ~lvl_i;
      end else begin : g_rise
         assign evt_o = lvl_i & ~prev_q;
      end
   endgenerate
endmodule

// File: rtl/pwr_evt_flag_bit.sv
`timescale 1ns/1ps
module pwr_evt_flag_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end
endmodule

// File: rtl/pwr_evt_flags.sv
`timescale 1ns/1ps
module pwr_evt_flags
   import pwr_evt_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit IRQ_REG     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              btn_i,
   input  logic              lock_i,
   input  logic              wake_btn_i,
   input  logic              wake_tmr_i,
   input  logic              lp_req_i,
   input  logic              wr_en_i,
   input  logic              wr_sel_i,
   input  logic [FLAG_W-1:0] wr_data_i,
   output logic [FLAG_W-1:0] flags_o,
   output logic [FLAG_W-1:0] enables_o,
   output logic              irq_o
);
   localparam int SYNC_W = 2;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pwr_evt_flags: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_W-1:0] lvl_sync;
   logic              btn_rise, lock_rise, lock_fall;
   logic              wake_brownout;
   flag_vec_t         set_vec, clr_vec, flag_q, en_q;
   logic              flag_wr, en_wr;

   pwr_evt_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({lock_i, btn_i}),
      .q_o   (lvl_sync)
   );

   pwr_evt_edge #(.FALLING(1'b0)) u_btn_rise (
      .clk(clk), .rst_n(rst_n), .lvl_i(lvl_sync[0]), .evt_o(btn_rise));
   pwr_evt_edge #(.FALLING(1'b0)) u_lock_rise (
      .clk(clk), .rst_n(rst_n), .lvl_i(lvl_sync[1]), .evt_o(lock_rise));
   pwr_evt_edge #(.FALLING(1'b1)) u_lock_fall (
      .clk(clk), .rst_n(rst_n), .lvl_i(lvl_sync[1]), .evt_o(lock_fall));

   assign wake_brownout = wake_btn_i | wake_tmr_i;

   always_comb begin
      set_vec            = '0;
      set_vec[IDX_BTN]   = btn_rise;
      set_vec[IDX_LRISE] = lock_rise;
      set_vec[IDX_LFALL] = lock_fall & ~wake_brownout;
   end

   assign flag_wr = wr_en_i & ~wr_sel_i;
   assign en_wr   = wr_en_i &  wr_sel_i;

   always_comb begin
      clr_vec          = {FLAG_W{flag_wr}} & ~wr_data_i;
      clr_vec[IDX_BTN] = clr_vec[IDX_BTN] | lp_req_i;
   end

   generate
      for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
         pwr_evt_flag_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_vec[i]),
            .clr_i (clr_vec[i]),
            .q_o   (flag_q[i])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q <= '0;
      else if (en_wr) en_q <= wr_data_i;
   end

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= |(flag_q & en_q);
         end
         assign irq_o = irq_q;
      end else begin : g_irq_comb
         assign irq_o = |(flag_q & en_q);
      end
   endgenerate

   assign flags_o   = flag_q;
   assign enables_o = en_q;
endmodule

// File: rtl/pwr_evt_flags_chk.sv
`timescale 1ns/1ps
module pwr_evt_flags_chk
   import pwr_evt_pkg::*;
#(
   parameter bit IRQ_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wake_btn_i,
   input logic              wake_tmr_i,
   input logic              lp_req_i,
   input logic              wr_en_i,
   input logic              wr_sel_i,
   input logic [FLAG_W-1:0] wr_data_i,
   input logic [FLAG_W-1:0] flags_o,
   input logic [FLAG_W-1:0] enables_o,
   input logic              irq_o
);
   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (flags_o == '0 && enables_o == '0));

   p_fall_suppressed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_o[IDX_LFALL]) |-> !$past(wake_btn_i || wake_tmr_i));

   p_enable_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_sel_i) |=> enables_o == $past(wr_data_i));

   p_enable_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_i && wr_sel_i) |=> $stable(enables_o));

   generate
      if (!IRQ_REG) begin : g_irq_chk
         p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o |-> (flags_o != '0 && enables_o != '0));
      end
      for (genvar i = 0; i < FLAG_W; i++) begin : g_sticky
         p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_o[i] && !(wr_en_i && !wr_sel_i && !wr_data_i[i])
             && !((i == IDX_BTN) && lp_req_i)) |=> flags_o[i]);
      end
   endgenerate
endmodule

bind pwr_evt_flags pwr_evt_flags_chk #(.IRQ_REG(IRQ_REG)) u_chk (.*);

// File: tb/pwr_evt_flags_tb.sv
`timescale 1ns/1ps
module pwr_evt_flags_tb;
   localparam int SYNC = 2;
   localparam int LAT  = SYNC + 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       btn_i = 1'b0, lock_i = 1'b0;
   logic       wake_btn_i = 1'b0, wake_tmr_i = 1'b0;
   logic       lp_req_i = 1'b0, wr_en_i = 1'b0, wr_sel_i = 1'b0;
   logic [2:0] wr_data_i = 3'b000;
   logic [2:0] flags_o, enables_o;
   logic       irq_o;

   int checks = 0, failures = 0;
   logic [2:0] exp_f = 3'b000, exp_e = 3'b000;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pwr_evt_flags #(.SYNC_STAGES(SYNC), .IRQ_REG(1'b0)) u_dut (.*);

   function automatic logic [2:0] f_after_clear(logic [2:0] f, logic wr, logic sel,
                                                logic [2:0] d, logic lp);
      logic [2:0] r = f;
      if (wr && !sel) r = r & d;
      if (lp) r[0] = 1'b0;
      return r;
   endfunction

   function automatic logic f_irq(logic [2:0] f, logic [2:0] e);
      return |(f & e);
   endfunction

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic chk_all(string req);
      chk({req, " flags"}, flags_o, exp_f);
      chk({req, " enables"}, enables_o, exp_e);
      chk({req, " irq"}, irq_o, f_irq(exp_f, exp_e));
   endtask

   task automatic do_write(logic sel, logic [2:0] d);
      wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
      tick(1);
      wr_en_i = 1'b0;
      if (sel) exp_e = d;
      else     exp_f = exp_f & d;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      tick(3);
      chk_all("R1 in reset");
      rst_n = 1'b1;
      tick(4);
      chk_all("R1 after reset");

      do_write(1'b1, 3'b111);
      chk_all("R9 enable load");

      // R2 latency and polarity
      btn_i = 1'b1;
      tick(LAT - 1);
      chk("R2 early", flags_o[0], 1'b0);
      tick(1);
      exp_f[0] = 1'b1;
      chk_all("R2 set");
      btn_i = 1'b0;
      tick(LAT + 2);
      chk_all("R2 fall no effect R11 sticky");

      do_write(1'b0, 3'b110);
      chk_all("R6 clear bit0 only");

      // R3
      lock_i = 1'b1;
      tick(LAT - 1);
      chk("R3 early", flags_o[1], 1'b0);
      tick(1);
      exp_f[1] = 1'b1;
      chk_all("R3 set");
      do_write(1'b0, 3'b111);
      chk_all("R6 ones no effect");
      do_write(1'b0, 3'b101);
      chk_all("R6 clear bit1");

      // R4
      lock_i = 1'b0;
      tick(LAT);
      exp_f[2] = 1'b1;
      chk_all("R4 set");
      do_write(1'b0, 3'b000);
      chk_all("R6 clear all");

      // R5 wake timer then wake button
      lock_i = 1'b1; tick(LAT + 1);
      do_write(1'b0, 3'b000);
      wake_tmr_i = 1'b1; lock_i = 1'b0;
      tick(LAT + 2);
      chk_all("R5 timer wake suppress");
      wake_tmr_i = 1'b0; tick(2);
      chk_all("R5 timer wake after");
      lock_i = 1'b1; tick(LAT + 1);
      do_write(1'b0, 3'b000);
      wake_btn_i = 1'b1; lock_i = 1'b0;
      tick(LAT + 2);
      chk_all("R5 button wake suppress");
      wake_btn_i = 1'b0; tick(2);

      // R7
      lock_i = 1'b1; btn_i = 1'b1;
      tick(LAT + 1);
      exp_f = 3'b011;
      chk_all("R7 setup");
      lp_req_i = 1'b1; tick(1); lp_req_i = 1'b0;
      exp_f = 3'b010;
      chk_all("R7 mode clear");

      // R8 event vs software clear
      btn_i = 1'b0; tick(LAT + 1);
      btn_i = 1'b1;
      tick(LAT - 1);
      wr_en_i = 1'b1; wr_sel_i = 1'b0; wr_data_i = 3'b000;
      tick(1);
      wr_en_i = 1'b0;
      exp_f = 3'b001;
      chk_all("R8 event beats write clear");
      // R8 event vs mode clear
      btn_i = 1'b0; tick(LAT + 1);
      do_write(1'b0, 3'b000);
      btn_i = 1'b1;
      tick(LAT - 1);
      lp_req_i = 1'b1; tick(1); lp_req_i = 1'b0;
      exp_f = 3'b001;
      chk_all("R8 event beats mode clear");

      // R10 masking
      do_write(1'b1, 3'b110);
      chk("R10 masked irq", irq_o, 1'b0);
      do_write(1'b1, 3'b001);
      chk("R10 enabled irq", irq_o, 1'b1);

      // random writes and mode requests with quiet inputs
      void'($urandom(32'h5eed_1234));
      for (int it = 0; it < 300; it++) begin
         logic wr, sel, lp;
         logic [2:0] d;
         wr = $urandom_range(0, 1); sel = $urandom_range(0, 1);
         lp = ($urandom_range(0, 7) == 0); d = $urandom_range(0, 7);
         wr_en_i = wr; wr_sel_i = sel; wr_data_i = d; lp_req_i = lp;
         tick(1);
         wr_en_i = 1'b0; lp_req_i = 1'b0;
         exp_f = f_after_clear(exp_f, wr, sel, d, lp);
         if (wr && sel) exp_e = d;
         chk_all("R6 R7 R9 R10 random");
      end

      // random spaced events
      for (int it = 0; it < 40; it++) begin
         int which;
         which = $urandom_range(0, 2);
         if (which == 0) begin
            btn_i = ~btn_i;
            tick(LAT + 1);
            if (btn_i) exp_f[0] = 1'b1;
            chk_all("R2 random edge");
         end else if (which == 1) begin
            lock_i = ~lock_i;
            tick(LAT + 1);
            if (lock_i) exp_f[1] = 1'b1; else exp_f[2] = 1'b1;
            chk_all("R3 R4 random edge");
         end else begin
            do_write(1'b0, 3'($urandom_range(0, 7)));
            chk_all("R6 random clear");
         end
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule